// File: doc/BRIEF.md
# Linked-List Transmit DMA Engine

This block is the outbound half of one DMA channel. A single start pulse hands it the address of the first descriptor in a chain held in word-addressed memory. Each descriptor occupies four consecutive 32-bit words: word 0 is the pointer to the next descriptor, word 1 is the first byte address of the payload, word 2 carries the control flags, and word 3 is the payload end address (exclusive). The engine fetches the descriptor and streams the payload words out. It then writes all four descriptor words back to the same place and either follows the next pointer or, at the end of the list, marks the channel context disabled and goes idle.

Packets are framed on the output stream. Before the first payload of a packet, the 16-bit tag from the descriptor's flag word is offered on a separate sideband. The last payload beat of a descriptor that closes a packet carries `last`. The data stream, the tag sideband and the memory request port all use valid/ready. A valid output keeps its payload steady until it is accepted, and the engine does not advance while a consumer holds ready low. Memory reads return in order on a response strobe, with only one access outstanding at a time.

Top module: `desc_tx_dma`

## Requirements
- R1: After reset `busy_o`, `eol_o`, `irq_data_o`, `mem_req_valid_o`, `md_valid_o` and `st_valid_o` are all low.
- R2: A start pulse while idle makes the engine read the descriptor words at offsets 0, 4, 8 and 12 from `head_addr_i`, in that order.
- R3: The tag in flag bits [31:16] is offered on `md_data_o` once, before any payload of a packet. A packet begins with the first descriptor after a start and with the first descriptor after one whose flag bit 3 is set. This holds even when that descriptor has no payload.
- R4: Payload words are read at addresses from word 1 upward in steps of 4, stopping before word 3. They are sent on `st_data_o` in address order. A descriptor whose word 1 equals word 3 sends no beats.
- R5: `st_last_o` is high only on the final payload beat of a descriptor whose flag bit 3 is set.
- R6: When a descriptor's payload is finished, its four words are written back unchanged to their own addresses, at offsets 0, 4, 8 and 12 in that order.
- R7: After the write-back of a descriptor with flag bit 4 set, `irq_data_o` is high for exactly one cycle. Descriptors with bit 4 clear give no pulse.
- R8: When flag bit 0 is clear, the next descriptor is fetched from the address held in word 0.
- R9: When flag bit 0 is set, the engine writes 0x00008000 to `ctx_addr_i`, raises `eol_o` and returns to idle. It then issues no memory request, tag or beat until the next start.
- R10: A start pulse clears `eol_o`. A start pulse while `busy_o` is high is ignored.
- R11: While any of the three valid outputs is high and its ready is low, that valid stays high and its payload stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only while idle |
| head_addr_i | input | AW | Address of the first descriptor |
| ctx_addr_i | input | AW | Address of the channel context word marked on end of list |
| busy_o | output | 1 | Engine is walking a chain |
| eol_o | output | 1 | End of list reached since the last start |
| irq_data_o | output | 1 | One-cycle pulse when a descriptor with the interrupt flag completes |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_we_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | AW | Byte address, word aligned |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read data strobe |
| mem_rsp_data_i | input | 32 | Read data |
| md_valid_o | output | 1 | Packet tag valid |
| md_ready_i | input | 1 | Packet tag accepted |
| md_data_o | output | 16 | Packet tag |
| st_valid_o | output | 1 | Payload beat valid |
| st_ready_i | input | 1 | Payload beat accepted |
| st_data_o | output | 32 | Payload word |
| st_last_o | output | 1 | Final beat of a packet |

## Verification
The assertions assume that the memory returns read data only while a read is outstanding, exactly one strobe per accepted read. They also assume that every descriptor has word-aligned pointers with the end at or above the start. The bench's memory model raises its response strobe only for a read it has just accepted, after a random delay of zero to two cycles. Every descriptor it builds takes its end pointer from the start pointer plus four times a non-negative word count. Ready on all three handshakes is withheld at random, so the hold rules run under heavy back-pressure.

// File: rtl/desc_tx_pkg.sv
package desc_tx_pkg;
  localparam int WORD_W     = 32;
  localparam int TAG_W      = 16;
  localparam int DESC_WORDS = 4;
  localparam int FL_EOL     = 0;
  localparam int FL_PKT_END = 3;
  localparam int FL_IRQ     = 4;
  localparam int TAG_LSB    = 16;
  localparam logic [WORD_W-1:0] CTX_DISABLE = 32'h0000_8000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DREQ, ST_DRSP, ST_DEC, ST_TAG, ST_PREQ,
    ST_PRSP, ST_PUSH, ST_WB, ST_FIN, ST_CTX
  } dtx_state_e;
endpackage

// File: rtl/desc_tx_walker.sv
module desc_tx_walker
  import desc_tx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start_i,
  input  logic [AW-1:0]                         head_addr_i,
  input  logic                                  mem_req_ready_i,
  input  logic                                  mem_rsp_valid_i,
  input  logic [WORD_W-1:0]                     mem_rsp_data_i,
  input  logic                                  md_ready_i,
  input  logic                                  st_ready_i,
  output dtx_state_e                            state_o,
  output logic [AW-1:0]                         cur_o,
  output logic [AW-1:0]                         pos_o,
  output logic [$clog2(DESC_WORDS)-1:0]         widx_o,
  output logic [DESC_WORDS-1:0][WORD_W-1:0]     desc_o,
  output logic                                  busy_o,
  output logic                                  eol_o,
  output logic                                  irq_o,
  output logic                                  md_valid_o,
  output logic [TAG_W-1:0]                      md_data_o,
  output logic                                  st_valid_o,
  output logic [WORD_W-1:0]                     st_data_o,
  output logic                                  st_last_o
);
  localparam int WIDX_W = $clog2(DESC_WORDS);
  localparam logic [WIDX_W-1:0] LAST_WIDX = WIDX_W'(DESC_WORDS - 1);

  dtx_state_e                      state;
  logic [AW-1:0]                   cur, pos, pos_nxt, end_ptr, buf_ptr;
  logic [WIDX_W-1:0]               widx;
  logic [DESC_WORDS-1:0][WORD_W-1:0] desc;
  logic [WORD_W-1:0]               data_q;
  logic                            eol_q, tag_due, irq_q;

  assign end_ptr = desc[3][AW-1:0];
  assign buf_ptr = desc[1][AW-1:0];
  assign pos_nxt = pos + AW'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur     <= '0;
      pos     <= '0;
      widx    <= '0;
      desc    <= '0;
      data_q  <= '0;
      eol_q   <= 1'b0;
      tag_due <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          cur     <= head_addr_i;
          eol_q   <= 1'b0;
          tag_due <= 1'b1;
          widx    <= '0;
          state   <= ST_DREQ;
        end
        ST_DREQ: if (mem_req_ready_i) state <= ST_DRSP;
        ST_DRSP: if (mem_rsp_valid_i) begin
          desc[widx] <= mem_rsp_data_i;
          if (widx == LAST_WIDX) state <= ST_DEC;
          else begin
            widx  <= widx + 1'b1;
            state <= ST_DREQ;
          end
        end
        ST_DEC: begin
          pos   <= buf_ptr;
          widx  <= '0;
          state <= tag_due ? ST_TAG : ((buf_ptr == end_ptr) ? ST_WB : ST_PREQ);
        end
        ST_TAG: if (md_ready_i) begin
          tag_due <= 1'b0;
          state   <= (pos == end_ptr) ? ST_WB : ST_PREQ;
        end
        ST_PREQ: if (mem_req_ready_i) state <= ST_PRSP;
        ST_PRSP: if (mem_rsp_valid_i) begin
          data_q <= mem_rsp_data_i;
          state  <= ST_PUSH;
        end
        ST_PUSH: if (st_ready_i) begin
          pos   <= pos_nxt;
          state <= (pos_nxt == end_ptr) ? ST_WB : ST_PREQ;
        end
        ST_WB: if (mem_req_ready_i) begin
          if (widx == LAST_WIDX) state <= ST_FIN;
          else widx <= widx + 1'b1;
        end
        ST_FIN: begin
          irq_q <= desc[2][FL_IRQ];
          if (desc[2][FL_PKT_END]) tag_due <= 1'b1;
          if (desc[2][FL_EOL]) begin
            eol_q <= 1'b1;
            state <= ST_CTX;
          end else begin
            cur   <= desc[0][AW-1:0];
            widx  <= '0;
            state <= ST_DREQ;
          end
        end
        ST_CTX: if (mem_req_ready_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state;
  assign cur_o      = cur;
  assign pos_o      = pos;
  assign widx_o     = widx;
  assign desc_o     = desc;
  assign busy_o     = (state != ST_IDLE);
  assign eol_o      = eol_q;
  assign irq_o      = irq_q;
  assign md_valid_o = (state == ST_TAG);
  assign md_data_o  = desc[2][TAG_LSB +: TAG_W];
  assign st_valid_o = (state == ST_PUSH);
  assign st_data_o  = data_q;
  assign st_last_o  = desc[2][FL_PKT_END] && (pos_nxt == end_ptr);

  assert_st_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_o && !st_ready_i |=> st_valid_o && $stable(st_data_o) && $stable(st_last_o));
  assert_md_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    md_valid_o && !md_ready_i |=> md_valid_o && $stable(md_data_o));
  assert_rsp_expected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid_i |-> (state == ST_DRSP || state == ST_PRSP));
  assert_last_then_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_o && st_ready_i && st_last_o |=> state == ST_WB);
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
endmodule

// File: rtl/desc_tx_memport.sv
module desc_tx_memport
  import desc_tx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  dtx_state_e                        state_i,
  input  logic [AW-1:0]                     cur_i,
  input  logic [AW-1:0]                     pos_i,
  input  logic [$clog2(DESC_WORDS)-1:0]     widx_i,
  input  logic [DESC_WORDS-1:0][WORD_W-1:0] desc_i,
  input  logic [AW-1:0]                     ctx_addr_i,
  input  logic                              mem_req_ready_i,
  output logic                              mem_req_valid_o,
  output logic                              mem_req_we_o,
  output logic [AW-1:0]                     mem_req_addr_o,
  output logic [WORD_W-1:0]                 mem_req_wdata_o
);
  logic [AW-1:0] desc_word_addr;
  assign desc_word_addr = cur_i + AW'({widx_i, 2'b00});

  always_comb begin
    mem_req_valid_o = 1'b0;
    mem_req_we_o    = 1'b0;
    mem_req_addr_o  = desc_word_addr;
    mem_req_wdata_o = desc_i[widx_i];
    unique case (state_i)
      ST_DREQ: mem_req_valid_o = 1'b1;
      ST_PREQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = pos_i;
      end
      ST_WB: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
      end
      ST_CTX: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
        mem_req_addr_o  = ctx_addr_i;
        mem_req_wdata_o = CTX_DISABLE;
      end
      default: ;
    endcase
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)
      && $stable(mem_req_we_o) && $stable(mem_req_wdata_o));
  assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> mem_req_addr_o[1:0] == 2'b00);
endmodule

// File: rtl/desc_tx_dma.sv
module desc_tx_dma
  import desc_tx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] head_addr_i,
  input  logic [AW-1:0] ctx_addr_i,
  output logic          busy_o,
  output logic          eol_o,
  output logic          irq_data_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [31:0]   mem_req_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [31:0]   mem_rsp_data_i,
  output logic          md_valid_o,
  input  logic          md_ready_i,
  output logic [15:0]   md_data_o,
  output logic          st_valid_o,
  input  logic          st_ready_i,
  output logic [31:0]   st_data_o,
  output logic          st_last_o
);
  localparam int WIDX_W = $clog2(DESC_WORDS);

  dtx_state_e                        state;
  logic [AW-1:0]                     cur, pos;
  logic [WIDX_W-1:0]                 widx;
  logic [DESC_WORDS-1:0][WORD_W-1:0] desc;

  desc_tx_walker #(.AW(AW)) u_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .head_addr_i(head_addr_i),
    .mem_req_ready_i(mem_req_ready_i), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .md_ready_i(md_ready_i), .st_ready_i(st_ready_i),
    .state_o(state), .cur_o(cur), .pos_o(pos), .widx_o(widx), .desc_o(desc),
    .busy_o(busy_o), .eol_o(eol_o), .irq_o(irq_data_o),
    .md_valid_o(md_valid_o), .md_data_o(md_data_o),
    .st_valid_o(st_valid_o), .st_data_o(st_data_o), .st_last_o(st_last_o)
  );

  desc_tx_memport #(.AW(AW)) u_memport (
    .clk(clk), .rst_n(rst_n), .state_i(state), .cur_i(cur), .pos_i(pos),
    .widx_i(widx), .desc_i(desc), .ctx_addr_i(ctx_addr_i),
    .mem_req_ready_i(mem_req_ready_i), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_we_o(mem_req_we_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_wdata_o(mem_req_wdata_o)
  );

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_valid_o && !md_valid_o && !st_valid_o);
  assert_one_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_req_valid_o, md_valid_o, st_valid_o}) <= 1);
endmodule

// File: tb/tb_desc_tx_dma.sv
`timescale 1ns/1ps
module tb_desc_tx_dma;
  localparam logic [31:0] CTX = 32'h0000_0FF0;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [31:0] head_addr_i = '0;
  logic busy_o, eol_o, irq_data_o;
  logic mem_req_valid_o, mem_req_ready_i = 1'b0, mem_req_we_o;
  logic [31:0] mem_req_addr_o, mem_req_wdata_o;
  logic mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic md_valid_o, md_ready_i = 1'b0;
  logic [15:0] md_data_o;
  logic st_valid_o, st_ready_i = 1'b0, st_last_o;
  logic [31:0] st_data_o;

  always #2 clk = ~clk;

  desc_tx_dma dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .head_addr_i(head_addr_i),
    .ctx_addr_i(CTX), .busy_o(busy_o), .eol_o(eol_o), .irq_data_o(irq_data_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_we_o(mem_req_we_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_wdata_o(mem_req_wdata_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .md_valid_o(md_valid_o), .md_ready_i(md_ready_i),
    .md_data_o(md_data_o), .st_valid_o(st_valid_o), .st_ready_i(st_ready_i),
    .st_data_o(st_data_o), .st_last_o(st_last_o)
  );

  typedef struct { logic is_tag; logic [31:0] data; logic last; } item_t;
  item_t       exp_out[$];
  logic [31:0] exp_rd[$];
  logic [31:0] exp_wa[$];
  logic [31:0] exp_wd[$];
  logic [31:0] mem [0:1023];
  int checks = 0, errors = 0, irq_cnt = 0, exp_irq = 0;
  logic tag_due_exp = 1'b0;
  logic rd_pend = 1'b0;
  int rd_dly = 0;
  logic [31:0] rd_addr = '0;
  int ready_pct = 75;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // driver: place one descriptor in memory and queue everything it should cause
  task automatic add_desc(input logic [31:0] a, nxt, bufa, input int nw, input logic [31:0] fl);
    item_t it;
    mem[a[11:2]]   = nxt;
    mem[a[11:2]+1] = bufa;
    mem[a[11:2]+2] = fl;
    mem[a[11:2]+3] = bufa + 32'(4*nw);
    for (int k = 0; k < 4; k++) exp_rd.push_back(a + 32'(4*k));
    if (tag_due_exp) begin
      it.is_tag = 1'b1; it.data = {16'h0, fl[31:16]}; it.last = 1'b0;
      exp_out.push_back(it);
      tag_due_exp = 1'b0;
    end
    for (int i = 0; i < nw; i++) begin
      exp_rd.push_back(bufa + 32'(4*i));
      it.is_tag = 1'b0; it.data = mem[bufa[11:2] + 10'(i)];
      it.last = (i == nw-1) && fl[3];
      exp_out.push_back(it);
    end
    for (int k = 0; k < 4; k++) begin
      exp_wa.push_back(a + 32'(4*k));
      exp_wd.push_back(mem[a[11:2] + 10'(k)]);
    end
    if (fl[4]) exp_irq++;
    if (fl[3]) tag_due_exp = 1'b1;
    if (fl[0]) begin
      exp_wa.push_back(CTX);
      exp_wd.push_back(32'h0000_8000);
    end
  endtask

  // memory model and monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rd_pend && rd_dly == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = mem[rd_addr[11:2]];
        rd_pend = 1'b0;
      end else begin
        mem_rsp_valid_i = 1'b0;
        if (rd_pend) rd_dly--;
      end
      mem_req_ready_i = ($urandom % 100) < ready_pct;
      st_ready_i      = ($urandom % 100) < ready_pct;
      md_ready_i      = ($urandom % 100) < ready_pct;
      #1;
      if (mem_req_valid_o && mem_req_ready_i) begin
        if (mem_req_we_o) begin
          if (exp_wa.size() == 0) chk(1'b0, "R9 unexpected write", mem_req_addr_o, 32'hx);
          else begin
            logic [31:0] ea, ed;
            ea = exp_wa.pop_front(); ed = exp_wd.pop_front();
            chk(mem_req_addr_o == ea, "R6 write address", mem_req_addr_o, ea);
            chk(mem_req_wdata_o == ed, "R6 write data", mem_req_wdata_o, ed);
          end
          mem[mem_req_addr_o[11:2]] = mem_req_wdata_o;
        end else begin
          if (exp_rd.size() == 0) chk(1'b0, "R9 unexpected read", mem_req_addr_o, 32'hx);
          else begin
            logic [31:0] ra;
            ra = exp_rd.pop_front();
            chk(mem_req_addr_o == ra, "R2 R4 read address", mem_req_addr_o, ra);
          end
          rd_pend = 1'b1; rd_dly = $urandom % 3; rd_addr = mem_req_addr_o;
        end
      end
      if (md_valid_o && md_ready_i) begin
        if (exp_out.size() == 0) chk(1'b0, "R3 unexpected tag", {16'h0, md_data_o}, 32'hx);
        else begin
          item_t e;
          e = exp_out.pop_front();
          chk(e.is_tag && md_data_o == e.data[15:0], "R3 tag", {16'h0, md_data_o}, e.data);
        end
      end
      if (st_valid_o && st_ready_i) begin
        if (exp_out.size() == 0) chk(1'b0, "R4 unexpected beat", st_data_o, 32'hx);
        else begin
          item_t e;
          e = exp_out.pop_front();
          chk(!e.is_tag && st_data_o == e.data, "R4 beat data", st_data_o, e.data);
          chk(st_last_o == e.last, "R5 last flag", 32'(st_last_o), 32'(e.last));
        end
      end
      if (irq_data_o) irq_cnt++;
    end
  end

  task automatic pulse_start(input logic [31:0] h);
    @(negedge clk);
    head_addr_i = h; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t;
    t = 0;
    while (busy_o && t < 20000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    chk(exp_out.size() == 0, "R4 stream queue drained", 32'(exp_out.size()), 0);
    chk(exp_rd.size() == 0, "R2 read queue drained", 32'(exp_rd.size()), 0);
    chk(exp_wa.size() == 0, "R6 write queue drained", 32'(exp_wa.size()), 0);
    chk(irq_cnt == exp_irq, "R7 interrupt pulses", 32'(irq_cnt), 32'(exp_irq));
    chk(eol_o == 1'b1, "R9 end-of-list flag", 32'(eol_o), 1);
    chk(busy_o == 1'b0, "R9 idle after list", 32'(busy_o), 0);
    $display("%s done", tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h5A00_0000 ^ (32'(i) << 8) ^ 32'(i * 7);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o, "R1 busy", 32'(busy_o), 0);
    chk(!eol_o, "R1 eol", 32'(eol_o), 0);
    chk(!mem_req_valid_o && !md_valid_o && !st_valid_o && !irq_data_o, "R1 valids",
        {28'h0, mem_req_valid_o, md_valid_o, st_valid_o, irq_data_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // single descriptor: packet end, interrupt, end of list
    tag_due_exp = 1'b1;
    add_desc(32'h100, 32'h0, 32'h400, 5, 32'hBEEF_0019);
    pulse_start(32'h100);
    wait_done("single");

    // chain of three under heavy back-pressure; R8 chaining, R3 re-tag, zero-length tail
    ready_pct = 35;
    tag_due_exp = 1'b1;
    add_desc(32'h200, 32'h210, 32'h500, 3, 32'h0A0A_0010);
    add_desc(32'h210, 32'h220, 32'h540, 2, 32'h0B0B_0008);
    add_desc(32'h220, 32'h0,   32'h580, 0, 32'h0C0C_0011);
    pulse_start(32'h200);
    // R10 start clears the end-of-list flag
    chk(eol_o == 1'b0 && busy_o, "R10 start clears eol", {30'h0, eol_o, busy_o}, 1);
    wait_done("chain");

    // R10 start while busy is ignored; R9 quiet after end of list
    ready_pct = 60;
    tag_due_exp = 1'b1;
    add_desc(32'h300, 32'h0, 32'h600, 8, 32'h1234_0001);
    pulse_start(32'h300);
    repeat (5) @(negedge clk);
    pulse_start(32'h380);
    wait_done("busy-start");
    repeat (30) @(negedge clk);
    chk(!busy_o && eol_o, "R9 stays idle with eol set", {30'h0, busy_o, eol_o}, 1);
    chk(exp_out.size() == 0 && exp_rd.size() == 0, "R10 ignored start had no effect",
        32'(exp_out.size() + exp_rd.size()), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule